// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the command front end of a NOR-style flash macro. A host writes byte commands on the low eight data bits through a synchronous write strobe. The block decodes them, runs the two-write program and erase sequences, and drives a behavioural write engine. The engine stays busy for a parameterised number of clock cycles and then commits the result to a small internal word array. An 8-bit status register reports whether the engine is ready, whether it is suspended, and any error flags. The read port returns array words, the status register, or the identifier codes, depending on the last command accepted.

Both program and erase can be suspended and resumed. An erase that is suspended still allows a program to a different block. While an operation runs, only the suspend command is accepted. A single supply-good input stands in for voltage sensing. An active-low reset/power-down input clears the status register and the engine. It does not clear the stored array.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset is released, the read port is in array mode. Status reads 0080h. A program that was running when reset was asserted leaves the array word unchanged.
- R2: Command 90h selects identifier mode. Word address 0 reads 002Ch. Word address 1 reads 4492h when TOP_BOOT=1 and 4493h when TOP_BOOT=0.
- R3: The program sequence is 10h or 40h followed by a data write. It ANDs the data into the addressed word after PGM_CYC busy cycles. Writing 1s leaves bits unchanged and sets no error.
- R4: 20h followed directly by D0h erases the whole block (2^BLK_LSB words) holding the confirm address to FFFFh after ERS_CYC cycles. Other blocks are untouched.
- R5: In an erase sequence, any second byte other than D0h starts nothing. It sets SR5 (bit 5) and SR4 (bit 4).
- R6: If supply_ok is low when a program or erase would start, nothing starts, the array is unchanged, and SR3 (bit 3) is set.
- R7: While the engine is busy, every command except B0h is ignored, and the read mode is unchanged.
- R8: B0h during a program suspends it, with SR2 (bit 2) = 1 and SR7 = 1. Only FFh, 70h and D0h are accepted then. D0h clears SR2 and completes the program.
- R9: B0h during an erase suspends it, with SR6 (bit 6) = 1 and SR7 = 1. A program to another block runs, and the erase stays suspended afterwards. A program to the suspended block is rejected with SR4. D0h resumes the erase.
- R10: The status value on the read port is captured when chip-enable and output-enable are both low for the first cycle. It holds while both stay low.
- R11: Command 50h clears SR5, SR4, SR3 and SR1 and returns to array mode.
- R12: A status read returns 00h in the upper byte. SR0 is 0. SR7 = 1 means ready and SR7 = 0 means busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset/power-down |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| wr_stb | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; commands on bits 7:0 |
| supply_ok | input | 1 | Programming supply within range |
| rdata | output | 16 | Read data; 0 while not selected |

## Verification
A write is accepted on the rising edge where the strobe is high. Its effect on the engine is visible from the next edge. The engine stays busy for exactly PGM_CYC or ERS_CYC edges after the accepting one, and it commits to the array on the last of those edges.

A read lowers both enables at a falling edge. The status capture happens on the following rising edge, and the bench samples at the falling edge after that. A read issued right after a write therefore sees the busy state. Every completion check waits several cycles beyond the busy window before it reads, so no check depends on the exact completion edge except the held-latch check, which deliberately spans it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        M_ARRAY,
        M_STATUS,
        M_IDENT,
        M_PGM_SETUP,
        M_ERS_SETUP
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERS
    } op_e;

    localparam logic [7:0] CMD_PGM_A   = 8'h10;
    localparam logic [7:0] CMD_PGM_B   = 8'h40;
    localparam logic [7:0] CMD_ERS     = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SUSP    = 8'hB0;
    localparam logic [7:0] CMD_RDSTAT  = 8'h70;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_RDARR   = 8'hFF;

    localparam logic [15:0] ID_MAKER   = 16'h002C;
    localparam logic [15:0] ID_DEV_TOP = 16'h4492;
    localparam logic [15:0] ID_DEV_BOT = 16'h4493;

endpackage

// File: rtl/flash_store.sv
module flash_store #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int BLK_LSB = 3
) (
    input  logic              clk,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Storage is not reset: it survives reset/power-down.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
        logic blk_hit_d;
        logic word_hit_d;
        always_comb begin
            blk_hit_d  = ers_en && (ers_addr[ADDR_W-1:BLK_LSB] == WA[ADDR_W-1:BLK_LSB]);
            word_hit_d = pgm_en && (pgm_addr == WA);
        end
        always_ff @(posedge clk) begin
            if (blk_hit_d)
                mem[g] <= '1;
            else if (word_hit_d)
                mem[g] <= mem[g] & pgm_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R4: the engine never commits a program and an erase together
    a_r4_single_commit: assert property (@(posedge clk) !(pgm_en && ers_en));

endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pgm,
    input  logic              start_ers,
    input  logic              suspend,
    input  logic              resume,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic              busy,
    output op_e               op,
    output logic              ers_susp,
    output logic              pgm_susp,
    output logic [ADDR_W-1:0] susp_addr,
    output logic              pgm_commit,
    output logic              ers_commit,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data
);
    localparam int CYC_MAX = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);

    typedef struct packed {
        op_e               op;
        logic              susp;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              park;
        logic [CNT_W-1:0]  park_cnt;
        logic [ADDR_W-1:0] park_addr;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d      = eng_q;
        pgm_commit = 1'b0;
        ers_commit = 1'b0;
        busy       = (eng_q.op != OP_NONE) && !eng_q.susp;
        if (start_pgm) begin
            if (eng_q.op == OP_ERS && eng_q.susp) begin
                eng_d.park      = 1'b1;
                eng_d.park_cnt  = eng_q.cnt;
                eng_d.park_addr = eng_q.addr;
            end
            eng_d.op   = OP_PGM;
            eng_d.susp = 1'b0;
            eng_d.cnt  = CNT_W'(PGM_CYC);
            eng_d.addr = tgt_addr;
            eng_d.data = tgt_data;
        end else if (start_ers) begin
            eng_d.op   = OP_ERS;
            eng_d.susp = 1'b0;
            eng_d.cnt  = CNT_W'(ERS_CYC);
            eng_d.addr = tgt_addr;
        end else if (suspend && busy) begin
            eng_d.susp = 1'b1;
        end else if (resume && eng_q.op != OP_NONE && eng_q.susp) begin
            eng_d.susp = 1'b0;
        end else if (busy) begin
            if (eng_q.cnt == CNT_W'(1)) begin
                pgm_commit = (eng_q.op == OP_PGM);
                ers_commit = (eng_q.op == OP_ERS);
                if (eng_q.park) begin
                    eng_d.op   = OP_ERS;
                    eng_d.susp = 1'b1;
                    eng_d.cnt  = eng_q.park_cnt;
                    eng_d.addr = eng_q.park_addr;
                    eng_d.park = 1'b0;
                end else begin
                    eng_d.op  = OP_NONE;
                    eng_d.cnt = '0;
                end
            end else begin
                eng_d.cnt = eng_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign op        = eng_q.op;
    assign ers_susp  = (eng_q.op == OP_ERS && eng_q.susp) || eng_q.park;
    assign pgm_susp  = (eng_q.op == OP_PGM) && eng_q.susp;
    assign susp_addr = eng_q.park ? eng_q.park_addr : eng_q.addr;
    assign cm_addr   = eng_q.addr;
    assign cm_data   = eng_q.data;

    // R3: a running operation always holds a live, in-range count
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (eng_q.cnt != '0 && eng_q.cnt <= CNT_W'(CYC_MAX)));

    // R8: suspension is only entered from a running operation
    a_r8_susp_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.susp) |-> $past(busy));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int BLK_LSB  = 3,
    parameter int PGM_CYC  = 8,
    parameter int ERS_CYC  = 20,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              supply_ok,
    output logic [15:0]       rdata
);
    localparam int DATA_W = 16;
    localparam logic [15:0] ID_DEV = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    typedef struct packed {
        rd_mode_e   mode;
        logic       ers_err;
        logic       pgm_err;
        logic       vlow;
        logic       sel;
        logic [7:0] lat;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              busy, ers_susp, pgm_susp;
    op_e               eng_op;
    logic [ADDR_W-1:0] susp_addr, cm_addr;
    logic [DATA_W-1:0] cm_data, arr_data;
    logic              pgm_commit, ers_commit;
    logic              start_pgm, start_ers, suspend, resume;
    logic              sel;
    logic [7:0]        cmd, status_now;

    flash_wr_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_pgm(start_pgm), .start_ers(start_ers),
        .suspend(suspend), .resume(resume),
        .tgt_addr(addr), .tgt_data(wdata),
        .busy(busy), .op(eng_op),
        .ers_susp(ers_susp), .pgm_susp(pgm_susp), .susp_addr(susp_addr),
        .pgm_commit(pgm_commit), .ers_commit(ers_commit),
        .cm_addr(cm_addr), .cm_data(cm_data)
    );

    flash_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(BLK_LSB)
    ) u_store (
        .clk(clk),
        .pgm_en(pgm_commit), .pgm_addr(cm_addr), .pgm_data(cm_data),
        .ers_en(ers_commit), .ers_addr(cm_addr),
        .rd_addr(addr), .rd_data(arr_data)
    );

    always_comb begin
        cmd        = wdata[7:0];
        sel        = !ce_n && !oe_n;
        status_now = {!busy, ers_susp, ctl_q.ers_err, ctl_q.pgm_err,
                      ctl_q.vlow, pgm_susp, 1'b0, 1'b0};
        ctl_d      = ctl_q;
        start_pgm  = 1'b0;
        start_ers  = 1'b0;
        suspend    = 1'b0;
        resume     = 1'b0;

        ctl_d.sel = sel;
        if (sel && !ctl_q.sel)
            ctl_d.lat = status_now;

        if (wr_stb) begin
            if (busy) begin
                suspend = (cmd == CMD_SUSP);
            end else if (ctl_q.mode == M_PGM_SETUP) begin
                if (!supply_ok)
                    ctl_d.vlow = 1'b1;
                else if (ers_susp &&
                         addr[ADDR_W-1:BLK_LSB] == susp_addr[ADDR_W-1:BLK_LSB])
                    ctl_d.pgm_err = 1'b1;
                else
                    start_pgm = 1'b1;
                ctl_d.mode = M_STATUS;
            end else if (ctl_q.mode == M_ERS_SETUP) begin
                if (cmd != CMD_CONFIRM) begin
                    ctl_d.ers_err = 1'b1;
                    ctl_d.pgm_err = 1'b1;
                end else if (!supply_ok) begin
                    ctl_d.vlow = 1'b1;
                end else begin
                    start_ers = 1'b1;
                end
                ctl_d.mode = M_STATUS;
            end else if (eng_op != OP_NONE) begin
                unique case (cmd)
                    CMD_RDARR:   ctl_d.mode = M_ARRAY;
                    CMD_RDSTAT:  ctl_d.mode = M_STATUS;
                    CMD_CONFIRM: begin
                        resume     = 1'b1;
                        ctl_d.mode = M_STATUS;
                    end
                    CMD_PGM_A, CMD_PGM_B: begin
                        if (eng_op == OP_ERS)
                            ctl_d.mode = M_PGM_SETUP;
                    end
                    default: ;
                endcase
            end else begin
                unique case (cmd)
                    CMD_RDARR:  ctl_d.mode = M_ARRAY;
                    CMD_RDSTAT: ctl_d.mode = M_STATUS;
                    CMD_IDENT:  ctl_d.mode = M_IDENT;
                    CMD_CLRSTAT: begin
                        ctl_d.ers_err = 1'b0;
                        ctl_d.pgm_err = 1'b0;
                        ctl_d.vlow    = 1'b0;
                        ctl_d.mode    = M_ARRAY;
                    end
                    CMD_PGM_A, CMD_PGM_B: ctl_d.mode = M_PGM_SETUP;
                    CMD_ERS:              ctl_d.mode = M_ERS_SETUP;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mode <= M_ARRAY;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (!sel) begin
            rdata = '0;
        end else begin
            unique case (ctl_q.mode)
                M_ARRAY: rdata = arr_data;
                M_IDENT: begin
                    if (addr == ADDR_W'(0))      rdata = ID_MAKER;
                    else if (addr == ADDR_W'(1)) rdata = ID_DEV;
                    else                         rdata = '0;
                end
                default: rdata = {8'h00, ctl_q.lat};
            endcase
        end
    end

    // R7: a non-suspend write while busy leaves the read mode alone
    a_r7_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && wdata[7:0] != CMD_SUSP) |=> $stable(ctl_q.mode));

    // R10: the captured status holds while both enables stay low
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && ctl_q.sel) |=> $stable(ctl_q.lat));

    // R12: status reads carry a zero upper byte and a zero SR0
    a_r12_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && ctl_q.mode == M_STATUS) |-> (rdata[15:8] == 8'h00 && rdata[0] == 1'b0));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int ADDR_W  = 6;
    localparam int PGM_CYC = 8;
    localparam int ERS_CYC = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, wr_stb = 1'b0, supply_ok = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata, rdata_b;
    int                total = 0, bad = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_LSB(3), .PGM_CYC(PGM_CYC),
                     .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .supply_ok(supply_ok), .rdata(rdata));

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_LSB(3), .PGM_CYC(PGM_CYC),
                     .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b0)) dut_bot (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .supply_ok(supply_ok), .rdata(rdata_b));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [15:0] d,
                          output logic [15:0] db);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; db = rdata_b;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
        logic [15:0] d, db;
        bus_rd(a, d, db);
        check(tag, d, exp);
    endtask

    task automatic erase_blk(input logic [ADDR_W-1:0] a);
        bus_wr(a, 16'h0020);
        bus_wr(a, 16'h00D0);
        wait_cyc(ERS_CYC + 4);
        bus_wr(a, 16'h00FF);
    endtask

    task automatic program_word(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_wr(a, 16'h0040);
        bus_wr(a, d);
        wait_cyc(PGM_CYC + 4);
        bus_wr(a, 16'h00FF);
    endtask

    task automatic t_reset_state;
        bus_wr(0, 16'h0070);
        rd_chk("R1 status after reset", 0, 16'h0080);
        rd_chk("R12 status shape", 5, 16'h0080);
    endtask

    task automatic t_ident;
        logic [15:0] d, db;
        bus_wr(0, 16'h0090);
        rd_chk("R2 maker code", 0, 16'h002C);
        bus_rd(1, d, db);
        check("R2 device code top", d, 16'h4492);
        check("R2 device code bottom", db, 16'h4493);
        bus_wr(0, 16'h00FF);
    endtask

    task automatic t_erase;
        for (int b = 0; b < 4; b++) erase_blk(ADDR_W'(b * 8));
        program_word(8, 16'h1111);
        program_word(16, 16'h2222);
        rd_chk("R3 program result", 8, 16'h1111);
        erase_blk(8);
        rd_chk("R4 erased first word", 8, 16'hFFFF);
        rd_chk("R4 erased last word", 15, 16'hFFFF);
        rd_chk("R4 neighbour block untouched", 16, 16'h2222);
    endtask

    task automatic t_program_and;
        program_word(0, 16'hF0F0);
        program_word(0, 16'h0FFF);
        rd_chk("R3 program ANDs bits", 0, 16'h00F0);
        bus_wr(0, 16'h0070);
        rd_chk("R3 no error on 1s", 0, 16'h0080);
        bus_wr(0, 16'h00FF);
    endtask

    task automatic t_busy_filter;
        bus_wr(0, 16'h0020);
        bus_wr(0, 16'h00D0);
        bus_wr(0, 16'h00FF);
        rd_chk("R7 read array ignored while busy", 0, 16'h0000);
        wait_cyc(ERS_CYC + 2);
        rd_chk("R12 ready after erase", 0, 16'h0080);
        bus_wr(0, 16'h00FF);
        rd_chk("R4 block0 erased", 0, 16'hFFFF);
    endtask

    task automatic t_bad_erase;
        program_word(0, 16'hA5A5);
        bus_wr(0, 16'h0020);
        bus_wr(0, 16'h0070);
        rd_chk("R5 sequence error bits", 0, 16'h00B0);
        bus_wr(0, 16'h0050);
        rd_chk("R11 clear returns to array; R5 no erase", 0, 16'hA5A5);
        bus_wr(0, 16'h0070);
        rd_chk("R11 error bits cleared", 0, 16'h0080);
        bus_wr(0, 16'h00FF);
    endtask

    task automatic t_supply_low;
        supply_ok = 1'b0;
        bus_wr(1, 16'h0040);
        bus_wr(1, 16'h0000);
        rd_chk("R6 supply abort bit, not busy", 1, 16'h0088);
        supply_ok = 1'b1;
        bus_wr(1, 16'h0050);
        rd_chk("R6 word unchanged", 1, 16'hFFFF);
        bus_wr(1, 16'h0070);
        rd_chk("R11 supply bit cleared", 1, 16'h0080);
        bus_wr(1, 16'h00FF);
    endtask

    task automatic t_latch;
        logic [15:0] d, db;
        bus_wr(2, 16'h0040);
        bus_wr(2, 16'hFFFE);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = 2;
        @(negedge clk);
        check("R10 busy captured", rdata, 16'h0000);
        wait_cyc(PGM_CYC + 3);
        check("R10 value held while enables low", rdata, 16'h0000);
        ce_n = 1'b1; oe_n = 1'b1;
        bus_rd(2, d, db);
        check("R10 recaptured after toggle", d, 16'h0080);
        bus_wr(2, 16'h00FF);
        rd_chk("R3 program with bit0 cleared", 2, 16'hFFFE);
    endtask

    task automatic t_pgm_susp;
        bus_wr(24, 16'h0010);
        bus_wr(24, 16'h00F0);
        rd_chk("R8 busy before suspend", 24, 16'h0000);
        bus_wr(24, 16'h00B0);
        rd_chk("R8 program suspended", 24, 16'h0084);
        bus_wr(24, 16'h0090);
        rd_chk("R8 identify ignored in program suspend", 0, 16'h0084);
        bus_wr(24, 16'h00D0);
        rd_chk("R8 resumed and busy", 24, 16'h0000);
        wait_cyc(PGM_CYC + 2);
        rd_chk("R8 completed after resume", 24, 16'h0080);
        bus_wr(24, 16'h00FF);
        rd_chk("R8 programmed data", 24, 16'h00F0);
    endtask

    task automatic t_ers_susp;
        program_word(9, 16'h0F0F);
        bus_wr(8, 16'h0020);
        bus_wr(8, 16'h00D0);
        bus_wr(8, 16'h00B0);
        rd_chk("R9 erase suspended", 8, 16'h00C0);
        bus_wr(17, 16'h0040);
        bus_wr(17, 16'h1234);
        rd_chk("R9 nested program busy, erase still suspended", 17, 16'h0040);
        wait_cyc(PGM_CYC + 2);
        rd_chk("R9 erase suspended after program", 17, 16'h00C0);
        bus_wr(17, 16'h00FF);
        rd_chk("R9 other block programmed", 17, 16'h1234);
        bus_wr(9, 16'h0040);
        bus_wr(9, 16'h0000);
        rd_chk("R9 same-block program rejected", 9, 16'h00D0);
        bus_wr(8, 16'h00D0);
        rd_chk("R9 erase resumed busy", 8, 16'h0010);
        wait_cyc(ERS_CYC + 2);
        rd_chk("R9 erase complete", 8, 16'h0090);
        bus_wr(8, 16'h0050);
        rd_chk("R9 suspended block erased", 9, 16'hFFFF);
    endtask

    task automatic t_reset_abort;
        bus_wr(25, 16'h0040);
        bus_wr(25, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(PGM_CYC + 2);
        rd_chk("R1 array mode and word unchanged after reset", 25, 16'hFFFF);
        bus_wr(25, 16'h0070);
        rd_chk("R1 status cleared by reset", 25, 16'h0080);
        bus_wr(25, 16'h00FF);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_state();
        t_ident();
        t_erase();
        t_program_and();
        t_busy_filter();
        t_bad_erase();
        t_supply_low();
        t_latch();
        t_pgm_susp();
        t_ers_susp();
        t_reset_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule